// File: doc/BRIEF.md
# Power-fail write-protect sequencer

This block sits between a host port and a memory array and decides, cycle by cycle, whether host accesses reach the array. A supply monitor reports a falling supply on an asynchronous input. The block then opens a grace window of fixed length. An access that was already running when the failure was seen may finish inside that window. When the window closes the array is locked even if that access is still active, and the cut-off access is flagged with an abort pulse.

While locked, the array is deselected, the read path toward the host is parked and undriven, and nothing the host does has any effect. When the supply report clears, the lock is held for a separate settling period before accesses pass again. If the supply drops again during that period, the lock is re-entered at once. A second, lower-threshold supply input is synchronized and reported as a backup-power select.

Top module: `pfail_guard`

## Requirements
- R1: After reset `state_code` is 0, and `mem_sel`, `backup_sel` and `access_abort` are low.
- R2: In state 0 (normal), `mem_sel` equals `host_req`, `mem_we` is `host_req & host_we`, `host_rd_oe` is `host_req & ~host_we`, address and write data pass through, and `host_rdata` carries `mem_rdata` while `host_rd_oe` is high.
- R3: When `pwr_fail_a` rises, `state_code` becomes 1 (grace window) on the third rising clock edge, stays 1 for exactly TWP_CYC cycles, then becomes 2 (locked).
- R4: An access that is active (`host_req` high) at the edge that enters state 1 keeps `mem_sel` high for as long as `host_req` stays high inside the window.
- R5: In state 1, once the running access has ended, or if none was running on entry, `mem_sel` and `mem_we` stay low even when `host_req` rises again.
- R6: If the running access is still active when the window ends, `access_abort` is high for exactly one cycle, the first cycle of state 2, and `mem_sel` is low in that cycle; if it ended in time, `access_abort` stays low.
- R7: In state 2, `mem_sel`, `mem_we` and `host_rd_oe` are low, `host_rdata`, `mem_addr` and `mem_wdata` are zero, whatever the host inputs are.
- R8: When `pwr_fail_a` falls in state 2, `state_code` becomes 3 (settling) on the third rising edge, stays 3 for exactly TER_CYC cycles with `mem_sel` low, then returns to 0.
- R9: If the synchronized failure reasserts in state 3, the next state is 2, and a later recovery again lasts the full TER_CYC cycles.
- R10: `backup_sel` follows `low_volt_a` after two rising clock edges, in any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail_a | input | 1 | Asynchronous supply-failing report |
| low_volt_a | input | 1 | Asynchronous below-backup-threshold report |
| host_req | input | 1 | Host access active (held for the access length) |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data toward host, zero when not driven |
| host_rd_oe | output | 1 | Read data valid/driven toward host |
| mem_sel | output | 1 | Array select |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | DATA_W | Array write data |
| mem_rdata | input | DATA_W | Array read data |
| backup_sel | output | 1 | Select backup power source |
| access_abort | output | 1 | One-cycle pulse: access cut off by the lock |
| state_code | output | 2 | 0 normal, 1 grace window, 2 locked, 3 settling |

## Verification
A wrong control state shows at the ports in the same cycle, because the array select and write enable are decoded straight from the state register: a lock entered too late lets a write reach the array, and a lock released too early passes a read back during settling. A miscounted delay moves the change of `state_code` by whole cycles, so the bench checks the state on the exact cycles the window and settling period should end. A lost in-flight flag shows either as a missing abort pulse in the first locked cycle or as a host access that restarts inside the grace window.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

   typedef enum logic [1:0] {
      PG_NORMAL  = 2'd0,
      PG_PENDING = 2'd1,
      PG_LOCKED  = 2'd2,
      PG_SETTLE  = 2'd3
   } pg_state_e;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_a,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din_a};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/pfg_downcnt.sv
module pfg_downcnt #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic en,
   output logic zero
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("pfg_downcnt: LIMIT must be at least 1");
   end

   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] START = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= START;
      else if (en && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
   import pfg_pkg::*;
#(
   parameter int TWP_CYC = 16,
   parameter int TER_CYC = 32
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pf_s,
   input  logic      host_req,
   output pg_state_e state,
   output logic      inflight,
   output logic      abort_q
);

   pg_state_e state_nx;
   logic      wp_load, wp_zero;
   logic      er_load, er_zero;
   logic      inflight_nx;
   logic      cut_off;

   pfg_downcnt #(.LIMIT(TWP_CYC)) u_wp_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wp_load),
      .en    (state == PG_PENDING),
      .zero  (wp_zero)
   );

   pfg_downcnt #(.LIMIT(TER_CYC)) u_er_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (er_load),
      .en    (state == PG_SETTLE),
      .zero  (er_zero)
   );

   assign cut_off = (state == PG_PENDING) && wp_zero && inflight && host_req;

   always_comb begin
      state_nx    = state;
      wp_load     = 1'b0;
      er_load     = 1'b0;
      inflight_nx = 1'b0;
      unique case (state)
         PG_NORMAL: begin
            if (pf_s) begin
               state_nx    = PG_PENDING;
               wp_load     = 1'b1;
               inflight_nx = host_req;
            end
         end
         PG_PENDING: begin
            if (wp_zero) state_nx = PG_LOCKED;
            else         inflight_nx = inflight && host_req;
         end
         PG_LOCKED: begin
            if (!pf_s) begin
               state_nx = PG_SETTLE;
               er_load  = 1'b1;
            end
         end
         PG_SETTLE: begin
            if (pf_s) begin
               state_nx = PG_LOCKED;
               er_load  = 1'b1;
            end else if (er_zero) begin
               state_nx = PG_NORMAL;
            end
         end
         default: state_nx = PG_LOCKED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PG_NORMAL;
         inflight <= 1'b0;
         abort_q  <= 1'b0;
      end else begin
         state    <= state_nx;
         inflight <= inflight_nx;
         abort_q  <= cut_off;
      end
   end

endmodule

// File: rtl/pfg_gate.sv
module pfg_gate #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic              open_path,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_sel,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              host_rd_oe,
   output logic [DATA_W-1:0] host_rdata
);

   assign mem_sel    = open_path && host_req;
   assign mem_we     = mem_sel && host_we;
   assign host_rd_oe = mem_sel && !host_we;
   assign host_rdata = host_rd_oe ? mem_rdata : '0;

   if (PARK_ZERO) begin : g_park
      assign mem_addr  = open_path ? host_addr  : '0;
      assign mem_wdata = open_path ? host_wdata : '0;
   end else begin : g_thru
      assign mem_addr  = host_addr;
      assign mem_wdata = host_wdata;
   end

endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
   import pfg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int TWP_CYC     = 16,
   parameter int TER_CYC     = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit PARK_ZERO   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail_a,
   input  logic              low_volt_a,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rd_oe,
   output logic              mem_sel,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              backup_sel,
   output logic              access_abort,
   output logic [1:0]        state_code
);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pfail_guard: ADDR_W and DATA_W must be positive");
   end
   if (TWP_CYC < 1 || TER_CYC < 1) begin : g_bad_delay
      $error("pfail_guard: delays must be at least one cycle");
   end

   logic      pf_s;
   logic      inflight;
   logic      open_path;
   pg_state_e state;

   pfg_sync #(.STAGES(SYNC_STAGES)) u_pf_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din_a (pwr_fail_a),
      .dout  (pf_s)
   );

   pfg_sync #(.STAGES(SYNC_STAGES)) u_lv_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din_a (low_volt_a),
      .dout  (backup_sel)
   );

   pfg_ctrl #(.TWP_CYC(TWP_CYC), .TER_CYC(TER_CYC)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .pf_s     (pf_s),
      .host_req (host_req),
      .state    (state),
      .inflight (inflight),
      .abort_q  (access_abort)
   );

   assign open_path = (state == PG_NORMAL) || (state == PG_PENDING && inflight);

   pfg_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARK_ZERO(PARK_ZERO)) u_gate (
      .open_path  (open_path),
      .host_req   (host_req),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .mem_rdata  (mem_rdata),
      .mem_sel    (mem_sel),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .host_rd_oe (host_rd_oe),
      .host_rdata (host_rdata)
   );

   assign state_code = state;

endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk #(
   parameter int TWP_CYC = 16,
   parameter int TER_CYC = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] state_code,
   input logic       mem_sel,
   input logic       mem_we,
   input logic       host_rd_oe,
   input logic       host_req,
   input logic       access_abort,
   input logic       pf_s
);

   localparam int WW = $clog2(TWP_CYC + 2);
   localparam int RW = $clog2(TER_CYC + 2);

   logic [WW-1:0] win_len;
   logic [RW-1:0] set_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_len <= '0;
         set_len <= '0;
      end else begin
         win_len <= (state_code == 2'd1) ? win_len + 1'b1 : '0;
         set_len <= (state_code == 2'd3) ? set_len + 1'b1 : '0;
      end
   end

   a_r2_normal_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd0) |-> (mem_sel == host_req));

   a_r3_window_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd1) |=> (state_code == 2'd1 || state_code == 2'd2));

   a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
      (win_len <= WW'(TWP_CYC)));

   a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd1 && $past(state_code) == 2'd1 && !$past(mem_sel)) |-> !mem_sel);

   a_r6_abort_locked: assert property (@(posedge clk) disable iff (!rst_n)
      access_abort |-> (state_code == 2'd2 && !mem_sel));

   a_r7_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd2) |-> (!mem_sel && !mem_we && !host_rd_oe));

   a_r8_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
      (set_len <= RW'(TER_CYC)));

   a_r9_relock: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'd3 && pf_s) |=> (state_code == 2'd2));

endmodule

bind pfail_guard pfail_guard_chk #(.TWP_CYC(TWP_CYC), .TER_CYC(TER_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .state_code   (state_code),
   .mem_sel      (mem_sel),
   .mem_we       (mem_we),
   .host_rd_oe   (host_rd_oe),
   .host_req     (host_req),
   .access_abort (access_abort),
   .pf_s         (pf_s)
);

// File: tb/pfail_guard_bench.sv
`timescale 1ns/1ps
module pfail_guard_bench;

   localparam int AW  = 8;
   localparam int DW  = 8;
   localparam int TWP = 5;
   localparam int TER = 7;

   localparam int S_ST = 0, S_SEL = 1, S_WE = 2, S_OE = 3, S_ABT = 4,
                  S_BK = 5, S_ADDR = 6, S_RD = 7, S_WD = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwr_fail_a = 1'b0, low_volt_a = 1'b0;
   logic          host_req = 1'b0, host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0, mem_rdata = '0;
   logic [DW-1:0] host_rdata, mem_wdata;
   logic [AW-1:0] mem_addr;
   logic          host_rd_oe, mem_sel, mem_we, backup_sel, access_abort;
   logic [1:0]    state_code;

   always #5 clk = ~clk;

   pfail_guard #(.ADDR_W(AW), .DATA_W(DW), .TWP_CYC(TWP), .TER_CYC(TER)) u_pfail_guard (
      .clk(clk), .rst_n(rst_n), .pwr_fail_a(pwr_fail_a), .low_volt_a(low_volt_a),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rd_oe(host_rd_oe),
      .mem_sel(mem_sel), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .backup_sel(backup_sel), .access_abort(access_abort),
      .state_code(state_code)
   );

   typedef struct {
      int          due;
      int          sel;
      logic [31:0] val;
      string       req;
   } item_t;

   item_t sbq[$];
   int    cyc = 0;
   int    checks = 0;
   int    bad = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] observe(int sel);
      case (sel)
         S_ST:   return 32'(state_code);
         S_SEL:  return 32'(mem_sel);
         S_WE:   return 32'(mem_we);
         S_OE:   return 32'(host_rd_oe);
         S_ABT:  return 32'(access_abort);
         S_BK:   return 32'(backup_sel);
         S_ADDR: return 32'(mem_addr);
         S_RD:   return 32'(host_rdata);
         default: return 32'(mem_wdata);
      endcase
   endfunction

   // driver side: queue an expectation dly rising edges from now
   task automatic expect_at(int sel, logic [31:0] val, int dly, string req);
      item_t it;
      it.due = cyc + dly; it.sel = sel; it.val = val; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare due items shortly after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
               logic [31:0] got;
               got = observe(sbq[i].sel);
               checks++;
               if (got !== sbq[i].val) begin
                  bad++;
                  $display("FAIL %s sel=%0d cyc=%0d actual=%0h expected=%0h",
                           sbq[i].req, sbq[i].sel, cyc, got, sbq[i].val);
               end
               sbq.delete(i);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      expect_at(S_ST, 0, 0, "R1");
      expect_at(S_SEL, 0, 0, "R1");
      expect_at(S_BK, 0, 0, "R1");
      expect_at(S_ABT, 0, 0, "R1");
      tick(1);

      // R2 normal write then read
      host_req = 1; host_we = 1; host_addr = 8'h12; host_wdata = 8'hA5;
      expect_at(S_SEL, 1, 0, "R2");
      expect_at(S_WE, 1, 0, "R2");
      expect_at(S_ADDR, 32'h12, 0, "R2");
      expect_at(S_WD, 32'hA5, 0, "R2");
      expect_at(S_OE, 0, 0, "R2");
      tick(1);
      host_we = 0; mem_rdata = 8'h3C;
      expect_at(S_OE, 1, 0, "R2");
      expect_at(S_RD, 32'h3C, 0, "R2");
      expect_at(S_WE, 0, 0, "R2");
      tick(1);

      // R3/R4/R6: failure with a write that outlives the window
      host_we = 1; host_addr = 8'h40; pwr_fail_a = 1;
      expect_at(S_ST, 0, 2, "R3");
      expect_at(S_ST, 1, 3, "R3");
      expect_at(S_SEL, 1, 3 + TWP - 1, "R4");
      expect_at(S_WE, 1, 3 + TWP - 1, "R4");
      expect_at(S_ST, 1, 3 + TWP - 1, "R3");
      expect_at(S_ST, 2, 3 + TWP, "R3");
      expect_at(S_ABT, 1, 3 + TWP, "R6");
      expect_at(S_SEL, 0, 3 + TWP, "R6");
      expect_at(S_ABT, 0, 4 + TWP, "R6");
      tick(4 + TWP);

      // R7 locked: host activity has no effect
      host_we = 0; mem_rdata = 8'h77; host_addr = 8'h99;
      expect_at(S_SEL, 0, 0, "R7");
      expect_at(S_OE, 0, 0, "R7");
      expect_at(S_RD, 0, 0, "R7");
      expect_at(S_ADDR, 0, 0, "R7");
      tick(1);
      host_we = 1; host_wdata = 8'hEE;
      expect_at(S_WE, 0, 0, "R7");
      expect_at(S_WD, 0, 0, "R7");
      tick(1);

      // R8 recovery with settling delay
      host_we = 0; mem_rdata = 8'h5A; pwr_fail_a = 0;
      expect_at(S_ST, 2, 2, "R8");
      expect_at(S_ST, 3, 3, "R8");
      expect_at(S_SEL, 0, 3, "R8");
      expect_at(S_ST, 3, 2 + TER, "R8");
      expect_at(S_SEL, 0, 2 + TER, "R8");
      expect_at(S_ST, 0, 3 + TER, "R8");
      expect_at(S_SEL, 1, 3 + TER, "R8");
      expect_at(S_RD, 32'h5A, 3 + TER, "R8");
      tick(4 + TER);

      // R5 access ends early inside the window, then restart attempt
      host_we = 1; pwr_fail_a = 1;
      tick(4);
      host_req = 0;
      expect_at(S_SEL, 0, 0, "R5");
      expect_at(S_ST, 1, 0, "R5");
      tick(1);
      host_req = 1;
      expect_at(S_SEL, 0, 0, "R5");
      expect_at(S_WE, 0, 0, "R5");
      expect_at(S_ST, 2, 3, "R6");
      expect_at(S_ABT, 0, 3, "R6");
      tick(4);

      // R9 failure returns during settling; full reload afterwards
      pwr_fail_a = 0;
      tick(5);
      pwr_fail_a = 1;
      expect_at(S_ST, 3, 2, "R9");
      expect_at(S_ST, 2, 3, "R9");
      tick(4);
      pwr_fail_a = 0;
      expect_at(S_ST, 3, 3, "R9");
      expect_at(S_ST, 3, 2 + TER, "R9");
      expect_at(S_ST, 0, 3 + TER, "R9");
      tick(4 + TER);

      // R10 backup select follows low-voltage input
      low_volt_a = 1;
      expect_at(S_BK, 0, 1, "R10");
      expect_at(S_BK, 1, 2, "R10");
      tick(3);
      low_volt_a = 0;
      expect_at(S_BK, 1, 1, "R10");
      expect_at(S_BK, 0, 2, "R10");
      tick(3);

      tick(2);
      if (sbq.size() != 0) begin
         bad++;
         $display("FAIL scoreboard actual=%0d expected=0 pending items", sbq.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule